// File: doc/BRIEF.md
# Confidence-Driven Checkpoint Buffer Controller

This block decides when an out-of-order core snapshots its rename map, and it keeps the bookkeeping for a small ring of checkpoint slots. A table of saturating counters scores each fetched branch. A checkpoint is taken at any branch whose score is not at its ceiling, after a fixed number of instruction allocations, when a slot counter nears overflow, or on an external force request. Every slot counts its in-flight instructions. When the oldest slot drains to zero and a younger slot exists, the whole group is committed in one pulse.

The front end tags each new instruction with `cur_id` and reports completions by slot. A branch resolution trains the confidence table. A mispredicted resolution returns its own slot as the rollback target and discards every younger slot. The snapshot storage and the fetch redirect sit outside this block.

Top module: `ckpt_ctrl`

## Requirements
- R1: While and just after reset, exactly one slot (id 0) is held, `cur_id` is 0, `alloc_ready` is 1 and no event pulse is raised.
- R2: The confidence table holds 4-bit counters, all 0 after reset, indexed by the low `HIST_W` bits of the PC XOR the history. A correct resolution adds one and saturates at 15. A mispredicted one clears the counter. Only 15 counts as high confidence, and a high-confidence branch raises no checkpoint by itself.
- R3: A fetched branch with low confidence raises `ck_valid` in the same cycle, with `ck_id` equal to `cur_id` plus one modulo `NUM_SLOTS`.
- R4: Once `INTERVAL` allocations have been accepted since the last checkpoint or rollback, a checkpoint is requested every cycle until one is taken.
- R5: After a rollback, the next fetched branch requests a checkpoint whatever its confidence, until some checkpoint is taken. `force_req` requests a checkpoint in the cycle it is high.
- R6: When the youngest slot's count is at least 2^`CNT_W`−2, a checkpoint is requested. `alloc_ready` is low exactly while that count equals 2^`CNT_W`−1.
- R7: With all `NUM_SLOTS` slots held, every request is dropped without a checkpoint, and allocation continues into the youngest slot.
- R8: The oldest slot is released with `commit_valid`/`commit_id` in the same cycle, whenever its count is zero and at least two slots are held. Releases follow allocation order.
- R9: A resolution with `res_miss` raises `rb_valid` with `rb_id` equal to `res_id` in the same cycle. That slot becomes the youngest, with its count cleared, and all checkpoint requests and commits of that cycle are dropped.
- R10: `cur_id` is the youngest held slot. A checkpoint taken in one cycle becomes `cur_id` from the next cycle, and allocations made in the same cycle still count to the previous slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch was fetched this cycle |
| br_pc | input | PC_W | Fetched branch address |
| br_hist | input | HIST_W | Global history for the fetched branch |
| res_valid | input | 1 | A branch resolved this cycle |
| res_miss | input | 1 | The resolved branch was mispredicted |
| res_pc | input | PC_W | Resolved branch address |
| res_hist | input | HIST_W | History used when the resolved branch was fetched |
| res_id | input | $clog2(NUM_SLOTS) | Slot the resolved branch is tagged with |
| force_req | input | 1 | External request for a checkpoint |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_ready | output | 1 | Allocation is accepted this cycle |
| done_valid | input | 1 | An instruction completed |
| done_id | input | $clog2(NUM_SLOTS) | Slot of the completed instruction |
| cur_id | output | $clog2(NUM_SLOTS) | Slot tag for new instructions |
| ck_valid | output | 1 | A checkpoint is taken this cycle |
| ck_id | output | $clog2(NUM_SLOTS) | Slot of the new checkpoint |
| commit_valid | output | 1 | Oldest slot released, its group commits |
| commit_id | output | $clog2(NUM_SLOTS) | Released slot |
| rb_valid | output | 1 | Rollback this cycle |
| rb_id | output | $clog2(NUM_SLOTS) | Slot to restore |

## Verification
Four results are combinational on the inputs and the held state, so they are due in the same cycle as their stimulus: `ck_valid`, `commit_valid`, `rb_valid` and `alloc_ready`. Their effects on `cur_id`, on the slot counts and on the next `ck_id` show one clock edge later. The bench changes inputs one time unit after a rising edge. At the following falling edge it compares every output with a queue-based model of the held slots. It then advances the model at the rising edge from the same inputs. That way each result is read in the cycle it belongs to, and each state change is read in the cycle after.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
  localparam int CONF_W = 4;
  localparam logic [CONF_W-1:0] CONF_TOP = '1;

  // saturating confidence step: a miss clears, a hit climbs to the top
  function automatic logic [CONF_W-1:0] conf_step(input logic [CONF_W-1:0] v,
                                                  input logic miss);
    if (miss) return '0;
    return (v == CONF_TOP) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/ckpt_conf_table.sv
module ckpt_conf_table
  import ckpt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [IDX_W-1:0] lk_hist,
  output logic             lk_high,
  input  logic             up_valid,
  input  logic             up_miss,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [IDX_W-1:0] up_hist
);
  localparam int DEPTH = 1 << IDX_W;

  logic [CONF_W-1:0] tbl [DEPTH];
  logic [IDX_W-1:0]  lk_idx, up_idx;

  assign lk_idx  = lk_pc[IDX_W-1:0] ^ lk_hist;
  assign up_idx  = up_pc[IDX_W-1:0] ^ up_hist;
  assign lk_high = (tbl[lk_idx] == CONF_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (up_valid) begin
      tbl[up_idx] <= conf_step(tbl[up_idx], up_miss);
    end
  end

  a_r2_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_miss |=> tbl[$past(up_idx)] == '0);
  a_r2_top_holds: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_miss && tbl[up_idx] == CONF_TOP |=> tbl[$past(up_idx)] == CONF_TOP);
endmodule

// File: rtl/ckpt_slot_fifo.sv
module ckpt_slot_fifo #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 6,
  localparam int IDW      = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             rollback,
  input  logic [IDW-1:0]   rb_slot,
  input  logic             inc,
  input  logic             dec,
  input  logic [IDW-1:0]   dec_slot,
  output logic [IDW-1:0]   head_slot,
  output logic [IDW-1:0]   tail_slot,
  output logic [IDW-1:0]   next_slot,
  output logic             full,
  output logic             pop,
  output logic [CNT_W-1:0] young_cnt
);
  localparam int OCC_W = IDW + 1;
  localparam logic [IDW-1:0] LAST = IDW'(NUM_SLOTS - 1);

  function automatic logic [IDW-1:0] wrap_inc(input logic [IDW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // number of slots from 'from' to 'to' inclusive, walking forward
  function automatic logic [OCC_W-1:0] span(input logic [IDW-1:0] from,
                                            input logic [IDW-1:0] to);
    logic [OCC_W-1:0] f, t;
    f = {1'b0, from};
    t = {1'b0, to};
    return (t >= f) ? t - f + 1'b1 : t + OCC_W'(NUM_SLOTS) - f + 1'b1;
  endfunction

  logic [IDW-1:0]   head, tail;
  logic [OCC_W-1:0] occ;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_vec;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CNT_W-1:0] c;
    logic hit_inc, hit_dec, clr;
    assign hit_inc = inc && (tail == IDW'(s));
    assign hit_dec = dec && (dec_slot == IDW'(s));
    assign clr     = (rollback && rb_slot == IDW'(s)) || (push && next_slot == IDW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   c <= '0;
      else if (clr)                 c <= '0;
      else if (hit_inc && !hit_dec) c <= c + 1'b1;
      else if (hit_dec && !hit_inc) c <= c - 1'b1;
    end
    assign cnt_vec[s] = c;
  end

  assign head_slot = head;
  assign tail_slot = tail;
  assign next_slot = wrap_inc(tail);
  assign full      = (occ == OCC_W'(NUM_SLOTS));
  assign young_cnt = cnt_vec[tail];
  assign pop       = !rollback && (occ >= OCC_W'(2)) && (cnt_vec[head] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= OCC_W'(1);
    end else if (rollback) begin
      tail <= rb_slot;
      occ  <= span(head, rb_slot);
    end else begin
      if (push) tail <= wrap_inc(tail);
      if (pop)  head <= wrap_inc(head);
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end

  a_r9_rb_clears_target: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> young_cnt == '0);
endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
  import ckpt_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 6,
  parameter int INTERVAL  = 256,
  parameter int PC_W      = 16,
  parameter int HIST_W    = 6,
  localparam int IDW      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [PC_W-1:0]   br_pc,
  input  logic [HIST_W-1:0] br_hist,
  input  logic              res_valid,
  input  logic              res_miss,
  input  logic [PC_W-1:0]   res_pc,
  input  logic [HIST_W-1:0] res_hist,
  input  logic [IDW-1:0]    res_id,
  input  logic              force_req,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic              done_valid,
  input  logic [IDW-1:0]    done_id,
  output logic [IDW-1:0]    cur_id,
  output logic              ck_valid,
  output logic [IDW-1:0]    ck_id,
  output logic              commit_valid,
  output logic [IDW-1:0]    commit_id,
  output logic              rb_valid,
  output logic [IDW-1:0]    rb_id
);
  localparam int SW = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [IDW-1:0]   LAST    = IDW'(NUM_SLOTS - 1);

  logic br_high, slots_full, want_ck, alloc_take, rec_pend;
  logic trig_branch, trig_interval, trig_overflow;
  logic [CNT_W-1:0] young_cnt;
  logic [IDW-1:0]   head_slot;
  logic [SW-1:0]    since;

  ckpt_conf_table #(.PC_W(PC_W), .IDX_W(HIST_W)) i_conf (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(br_pc), .lk_hist(br_hist), .lk_high(br_high),
    .up_valid(res_valid), .up_miss(res_miss), .up_pc(res_pc), .up_hist(res_hist)
  );

  ckpt_slot_fifo #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) i_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(ck_valid), .rollback(rb_valid), .rb_slot(res_id),
    .inc(alloc_take), .dec(done_valid), .dec_slot(done_id),
    .head_slot(head_slot), .tail_slot(cur_id), .next_slot(ck_id),
    .full(slots_full), .pop(commit_valid), .young_cnt(young_cnt)
  );

  assign commit_id     = head_slot;
  assign rb_valid      = res_valid && res_miss;
  assign rb_id         = res_id;
  assign trig_branch   = br_valid && (!br_high || rec_pend);
  assign trig_interval = (since == SW'(INTERVAL));
  assign trig_overflow = (young_cnt >= CNT_TOP - 1'b1);
  assign want_ck       = !rb_valid && (trig_branch || force_req || trig_interval || trig_overflow);
  assign ck_valid      = want_ck && !slots_full;
  assign alloc_ready   = (young_cnt != CNT_TOP);
  assign alloc_take    = alloc_valid && alloc_ready && !rb_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      rec_pend <= 1'b0;
    end else if (rb_valid) begin
      since    <= '0;
      rec_pend <= 1'b1;
    end else if (ck_valid) begin
      since    <= '0;
      rec_pend <= 1'b0;
    end else if (alloc_take && !trig_interval) begin
      since    <= since + 1'b1;
    end
  end

  a_r10_cur_follows_ck: assert property (@(posedge clk) disable iff (!rst_n)
    ck_valid |=> cur_id == $past(ck_id));
  a_r9_cur_after_rb: assert property (@(posedge clk) disable iff (!rst_n)
    rb_valid |=> cur_id == $past(rb_id));
  a_r8_commit_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid ||
      commit_id == (($past(commit_id) == LAST) ? '0 : $past(commit_id) + 1'b1));
endmodule

// File: tb/test_ckpt_ctrl.sv
`timescale 1ns/1ps
module test_ckpt_ctrl;
  localparam int N = 8, CW = 6, IV = 256, PW = 16, HW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic br_valid, res_valid, res_miss, force_req, alloc_valid, done_valid;
  logic [PW-1:0] br_pc, res_pc;
  logic [HW-1:0] br_hist, res_hist;
  logic [2:0] res_id, done_id;
  logic alloc_ready, ck_valid, commit_valid, rb_valid;
  logic [2:0] cur_id, ck_id, commit_id, rb_id;

  ckpt_ctrl i_ckpt_ctrl (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_pc(br_pc), .br_hist(br_hist),
    .res_valid(res_valid), .res_miss(res_miss), .res_pc(res_pc), .res_hist(res_hist),
    .res_id(res_id), .force_req(force_req),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .done_valid(done_valid), .done_id(done_id),
    .cur_id(cur_id), .ck_valid(ck_valid), .ck_id(ck_id),
    .commit_valid(commit_valid), .commit_id(commit_id),
    .rb_valid(rb_valid), .rb_id(rb_id)
  );

  int n_chk = 0, n_err = 0;
  int held[$];
  int cnt[N];
  int conf[64];
  int since;
  bit pend;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    br_valid = 0; br_pc = '0; br_hist = '0;
    res_valid = 0; res_miss = 0; res_pc = '0; res_hist = '0; res_id = '0;
    force_req = 0; alloc_valid = 0; done_valid = 0; done_id = '0;
  endtask

  function automatic int pick_done();
    int cand[$];
    foreach (held[i]) if (cnt[held[i]] > 0) cand.push_back(held[i]);
    if (cand.size() == 0) return -1;
    return cand[$urandom % cand.size()];
  endfunction

  // one cycle: compare at the falling edge, advance the model at the rising edge
  task automatic cyc(input string tag);
    bit rb, full, ck, cmt, rdy, acc;
    int y, nid, bidx, ridx;
    @(negedge clk);
    y    = held[$];
    rb   = res_valid && res_miss;
    full = (held.size() == N);
    bidx = (int'(br_pc) ^ int'(br_hist)) % 64;
    ridx = (int'(res_pc) ^ int'(res_hist)) % 64;
    rdy  = (cnt[y] != CMAX);
    ck   = !rb && !full && ((br_valid && (conf[bidx] != 15 || pend)) || force_req ||
                            since >= IV || cnt[y] >= CMAX - 1);
    nid  = (y + 1) % N;
    cmt  = !rb && held.size() >= 2 && cnt[held[0]] == 0;
    chk("R10 cur_id", int'(cur_id), y);
    chk("R6 alloc_ready", int'(alloc_ready), int'(rdy));
    chk({tag, " ck_valid"}, int'(ck_valid), int'(ck));
    if (ck) chk({tag, " ck_id"}, int'(ck_id), nid);
    chk("R8 commit_valid", int'(commit_valid), int'(cmt));
    if (cmt) chk("R8 commit_id", int'(commit_id), held[0]);
    chk("R9 rb_valid", int'(rb_valid), int'(rb));
    if (rb) chk("R9 rb_id", int'(rb_id), int'(res_id));
    @(posedge clk);
    acc = alloc_valid && rdy && !rb;
    if (res_valid) conf[ridx] = res_miss ? 0 : (conf[ridx] == 15 ? 15 : conf[ridx] + 1);
    if (acc) cnt[y]++;
    if (done_valid && !(rb && done_id == res_id)) cnt[done_id]--;
    if (rb) begin
      cnt[res_id] = 0;
      while (held[$] != int'(res_id)) void'(held.pop_back());
      since = 0;
      pend  = 1;
    end else begin
      if (ck) begin
        held.push_back(nid);
        cnt[nid] = 0;
        since = 0;
        pend  = 0;
      end else if (acc && since < IV) begin
        since++;
      end
      if (cmt) void'(held.pop_front());
    end
    #1;
    idle_inputs();
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d;
    rst_n = 0;
    idle_inputs();
    held.push_back(0);
    foreach (cnt[i]) cnt[i] = 0;
    foreach (conf[i]) conf[i] = 0;
    since = 0;
    pend  = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 cur_id", int'(cur_id), 0);
    chk("R1 alloc_ready", int'(alloc_ready), 1);
    chk("R1 ck_valid", int'(ck_valid), 0);
    chk("R1 commit_valid", int'(commit_valid), 0);
    chk("R1 rb_valid", int'(rb_valid), 0);
    rst_n = 1;
    cyc("R1");

    // R3: low-confidence branches fill the ring, each slot keeps one instruction
    for (int i = 0; i < 7; i++) begin
      alloc_valid = 1; br_valid = 1; br_pc = PW'(8 + i);
      cyc("R3");
    end
    // R7: ring full, branch dropped, allocation still accepted
    alloc_valid = 1; br_valid = 1; br_pc = PW'(15);
    cyc("R7");
    chk("R7 alloc_ready when full", int'(alloc_ready), 1);

    // R6: youngest count climbs to its limit while the ring is full
    for (int i = 0; i < 64; i++) begin
      alloc_valid = 1;
      cyc("R6");
    end
    // R8: draining the oldest slot releases it
    done_valid = 1; done_id = 3'(held[0]);
    cyc("R8");
    for (int i = 0; i < 3; i++) begin
      alloc_valid = 1;
      cyc("R6");
    end

    // R2: train indices 1 and 3 up to saturation
    for (int i = 0; i < 17; i++) begin
      res_valid = 1; res_pc = PW'(1); res_id = 3'(held[$]);
      cyc("R2");
      res_valid = 1; res_pc = PW'(3); res_id = 3'(held[$]);
      cyc("R2");
    end
    br_valid = 1; br_pc = PW'(1);
    cyc("R2");
    br_valid = 1; br_pc = PW'(16'h0043); br_hist = HW'(2);
    cyc("R2");
    br_valid = 1; br_pc = PW'(5);
    cyc("R3");
    br_valid = 1; br_pc = PW'(6);
    cyc("R3");

    // R9: rollback into the second held slot, same-cycle requests dropped
    res_valid = 1; res_miss = 1; res_pc = PW'(1);
    res_id = 3'(held[held.size() >= 2 ? 1 : 0]);
    alloc_valid = 1; force_req = 1; br_valid = 1; br_pc = PW'(5);
    cyc("R9");
    // R5: first branch after recovery is checkpointed despite high confidence
    br_valid = 1; br_pc = PW'(3);
    cyc("R5");
    br_valid = 1; br_pc = PW'(3);
    cyc("R2");
    force_req = 1;
    cyc("R5");

    // R4: steady allocation with matching completions reaches the interval
    alloc_valid = 1;
    cyc("R4");
    for (int i = 0; i < 300; i++) begin
      alloc_valid = 1;
      if (cnt[held[$]] > 0) begin done_valid = 1; done_id = 3'(held[$]); end
      cyc("R4");
    end

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      alloc_valid = ($urandom % 5) < 2;
      br_valid = ($urandom % 4) == 0;
      br_pc = PW'($urandom);
      br_hist = HW'($urandom);
      force_req = ($urandom % 60) == 0;
      if (($urandom % 2) == 0) begin
        d = pick_done();
        if (d >= 0) begin done_valid = 1; done_id = 3'(d); end
      end
      if (($urandom % 6) == 0) begin
        res_valid = 1;
        res_pc = PW'($urandom);
        res_hist = HW'($urandom);
        res_miss = ($urandom % 10) == 0;
        res_id = 3'(held[$urandom % held.size()]);
      end
      cyc("R10");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule